// File: doc/BRIEF.md
# Real-Time Clock Register Bank with Update Cycle, Alarm and Update-Ended Interrupts

This block is the register bank of a real-time clock. Software reaches it through an index/data pair. It writes an index with the data-select input low, then reads or writes the selected byte with data-select high. The bank holds the displayed time, three alarm bytes, four control/status bytes (A, B, C, D) and general-purpose storage up to the top of the address space.

An external calendar counter supplies the next time, already formatted as bytes, and a once-per-second tick. When the oscillator field of register A reads as running normally, each tick opens an update window of `UIP_CYCLES` clocks. Unless the freeze bit is set, the update-in-progress flag is visible during that window. When the window closes, the bank copies the incoming time into the readable time bytes. It then compares the incoming seconds, minutes and hours against the alarm bytes and posts alarm and update-ended flags in register C. An interrupt output follows the flags. Reading C through the data port returns the flags and then clears them along with the interrupt.

Top module: `rtc_regbank`

## Requirements
- R1: After reset, index 10 (A) reads 0x26, index 11 (B) reads 0x02, index 12 (C) reads 0x00, index 13 (D) reads 0x80, and `irq` is low.
- R2: An index write whose value is 128 or more leaves the current index unchanged. A data write stores the byte at the current index, and a data read returns the stored byte.
- R3: A tick is ignored, with no update window and no time copy, when bits 6:4 of A differ from 3'b010.
- R4: A tick accepted while idle with B bit 7 (freeze) clear sets A bit 7 for exactly `UIP_CYCLES` clocks after the tick edge. Ticks arriving during a window are ignored.
- R5: When a window closes with freeze clear, the time inputs are stored at indices 0 (seconds), 2 (minutes), 4 (hours), 6 (weekday), 7 (day), 8 (month) and 9 (year).
- R6: With freeze set, a tick raises no A bit 7, copies no time and posts no flag.
- R7: Alarm bytes sit at indices 1, 3 and 5. A byte whose bits 7:6 are 2'b11 matches anything; any other byte must equal the incoming seconds, minutes or hours. If B bit 5 is set and all three match at window close, C gains 0xA0 and `irq` rises.
- R8: If B bit 4 is set at window close with freeze clear, C gains 0x90 and `irq` rises.
- R9: A data read strobe at index 12 returns C and then clears C to 0x00 and drops `irq` on the following clock.
- R10: Data writes to C and D are ignored, and A bit 7 cannot be written by software.
- R11: `irq` is never high while C bit 7 is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_data | input | 1 | 0 selects the index register, 1 selects the data byte |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Data read strobe (read side effects) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Byte at the current index |
| sec_tick | input | 1 | One-clock pulse once per second |
| tm_sec | input | 8 | Next seconds value |
| tm_min | input | 8 | Next minutes value |
| tm_hour | input | 8 | Next hours value |
| tm_wday | input | 8 | Next weekday value |
| tm_mday | input | 8 | Next day-of-month value |
| tm_mon | input | 8 | Next month value |
| tm_year | input | 8 | Next year value |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume `sec_tick` is a single-clock pulse. They also assume the time inputs are stable at the clock edge that closes the update window, because the copy and the alarm compare sample them only there. The bench drives every input on the falling edge and holds the time inputs constant across each window. It changes them only while the block is idle. Ticks are spaced well beyond `UIP_CYCLES`, so no tick falls into an open window except where that case is exercised on purpose.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
   localparam int OFS_SEC   = 0;
   localparam int OFS_ASEC  = 1;
   localparam int OFS_MIN   = 2;
   localparam int OFS_AMIN  = 3;
   localparam int OFS_HOUR  = 4;
   localparam int OFS_AHOUR = 5;
   localparam int OFS_WDAY  = 6;
   localparam int OFS_MDAY  = 7;
   localparam int OFS_MON   = 8;
   localparam int OFS_YEAR  = 9;
   localparam int OFS_CTLA  = 10;
   localparam int OFS_CTLB  = 11;
   localparam int OFS_STAT  = 12;
   localparam int OFS_VALID = 13;

   localparam logic [7:0] RST_CTLA  = 8'h26;
   localparam logic [7:0] RST_CTLB  = 8'h02;
   localparam logic [7:0] RST_VALID = 8'h80;

   localparam int B_FREEZE = 7;
   localparam int B_AIE    = 5;
   localparam int B_UIE    = 4;

   localparam logic [2:0] OSC_RUN    = 3'b010;
   localparam logic [7:0] FLAG_ALARM = 8'hA0;
   localparam logic [7:0] FLAG_UPD   = 8'h90;
   localparam logic [1:0] ANY_CODE   = 2'b11;
endpackage

// File: rtl/rtc_index_port.sv
module rtc_index_port #(
   parameter int ADDR_W = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              idx_we,
   input  logic [7:0]        wdata,
   output logic [ADDR_W-1:0] idx
);
   logic accept;

   generate
      if (ADDR_W >= 8) begin : g_full
         assign accept = 1'b1;
      end else begin : g_range
         assign accept = (wdata[7:ADDR_W] == '0);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         idx <= '0;
      else if (idx_we && accept)
         idx <= wdata[ADDR_W-1:0];
   end
endmodule

// File: rtl/rtc_update_seq.sv
module rtc_update_seq #(
   parameter int UIP_CYCLES = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic osc_ok,
   input  logic freeze,
   output logic busy,
   output logic uip,
   output logic commit
);
   localparam int CNT_W = $clog2(UIP_CYCLES + 1);
   localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(UIP_CYCLES);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(1);

   logic [CNT_W-1:0] cnt;

   assign commit = busy && (cnt == CNT_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         uip  <= 1'b0;
         cnt  <= '0;
      end else if (busy) begin
         if (commit) begin
            busy <= 1'b0;
            uip  <= 1'b0;
         end
         cnt <= cnt - CNT_LAST;
      end else if (tick && osc_ok) begin
         busy <= 1'b1;
         uip  <= !freeze;
         cnt  <= CNT_LOAD;
      end
   end

   a_r4_uip_in_window: assert property (@(posedge clk) disable iff (!rst_n)
      uip |-> busy);
   a_r3_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !(tick && osc_ok)) |=> !busy);
   a_r4_window_opens: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && tick && osc_ok && !freeze) |=> uip);
endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match #(
   parameter int FIELDS = 3
) (
   input  logic [FIELDS-1:0][7:0] alarm,
   input  logic [FIELDS-1:0][7:0] now,
   output logic                   hit
);
   logic [FIELDS-1:0] field_ok;

   generate
      for (genvar f = 0; f < FIELDS; f++) begin : g_field
         assign field_ok[f] = (alarm[f][7:6] == rtc_pkg::ANY_CODE) ||
                              (alarm[f] == now[f]);
      end
   endgenerate

   assign hit = &field_ok;
endmodule

// File: rtl/rtc_regbank.sv
module rtc_regbank #(
   parameter int ADDR_W     = 7,
   parameter int UIP_CYCLES = 8
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sel_data,
   input  logic       wr_en,
   input  logic       rd_en,
   input  logic [7:0] wdata,
   output logic [7:0] rdata,
   input  logic       sec_tick,
   input  logic [7:0] tm_sec,
   input  logic [7:0] tm_min,
   input  logic [7:0] tm_hour,
   input  logic [7:0] tm_wday,
   input  logic [7:0] tm_mday,
   input  logic [7:0] tm_mon,
   input  logic [7:0] tm_year,
   output logic       irq
);
   import rtc_pkg::*;

   localparam int DEPTH = 1 << ADDR_W;
   localparam logic [ADDR_W-1:0] L_CTLA  = ADDR_W'(OFS_CTLA);
   localparam logic [ADDR_W-1:0] L_STAT  = ADDR_W'(OFS_STAT);
   localparam logic [ADDR_W-1:0] L_VALID = ADDR_W'(OFS_VALID);

   generate
      if (ADDR_W < 4 || ADDR_W > 8) begin : g_bad_addr
         $error("rtc_regbank: ADDR_W must be 4..8");
      end
      if (UIP_CYCLES < 1) begin : g_bad_uip
         $error("rtc_regbank: UIP_CYCLES must be at least 1");
      end
   endgenerate

   logic [7:0]        mem [DEPTH];
   logic [ADDR_W-1:0] idx;
   logic [7:0]        stat_q;
   logic              irq_q;
   logic              busy, uip, commit, commit_live;
   logic              alarm_hit, alarm_ev, upd_ev, rd_clear, data_we;
   logic [2:0][7:0]   alarm_vec, now_vec;

   rtc_index_port #(.ADDR_W(ADDR_W)) u_index (
      .clk    (clk),
      .rst_n  (rst_n),
      .idx_we (wr_en && !sel_data),
      .wdata  (wdata),
      .idx    (idx)
   );

   rtc_update_seq #(.UIP_CYCLES(UIP_CYCLES)) u_seq (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (sec_tick),
      .osc_ok (mem[OFS_CTLA][6:4] == OSC_RUN),
      .freeze (mem[OFS_CTLB][B_FREEZE]),
      .busy   (busy),
      .uip    (uip),
      .commit (commit)
   );

   assign alarm_vec = {mem[OFS_AHOUR], mem[OFS_AMIN], mem[OFS_ASEC]};
   assign now_vec   = {tm_hour, tm_min, tm_sec};

   rtc_alarm_match #(.FIELDS(3)) u_alarm (
      .alarm (alarm_vec),
      .now   (now_vec),
      .hit   (alarm_hit)
   );

   assign commit_live = commit && !mem[OFS_CTLB][B_FREEZE];
   assign alarm_ev    = commit_live && mem[OFS_CTLB][B_AIE] && alarm_hit;
   assign upd_ev      = commit_live && mem[OFS_CTLB][B_UIE];
   assign rd_clear    = sel_data && rd_en && (idx == L_STAT);
   assign data_we     = sel_data && wr_en && (idx != L_STAT) && (idx != L_VALID);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
         mem[OFS_CTLA]  <= RST_CTLA;
         mem[OFS_CTLB]  <= RST_CTLB;
         mem[OFS_VALID] <= RST_VALID;
      end else begin
         if (commit_live) begin
            mem[OFS_SEC]  <= tm_sec;
            mem[OFS_MIN]  <= tm_min;
            mem[OFS_HOUR] <= tm_hour;
            mem[OFS_WDAY] <= tm_wday;
            mem[OFS_MDAY] <= tm_mday;
            mem[OFS_MON]  <= tm_mon;
            mem[OFS_YEAR] <= tm_year;
         end
         if (data_we) mem[idx] <= wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat_q <= '0;
         irq_q  <= 1'b0;
      end else begin
         stat_q <= (rd_clear ? 8'h00 : stat_q)
                 | (alarm_ev ? FLAG_ALARM : 8'h00)
                 | (upd_ev   ? FLAG_UPD   : 8'h00);
         irq_q  <= (!rd_clear && irq_q) || alarm_ev || upd_ev;
      end
   end

   always_comb begin
      if (idx == L_CTLA)
         rdata = {uip, mem[OFS_CTLA][6:0]};
      else if (idx == L_STAT)
         rdata = stat_q;
      else
         rdata = mem[idx];
   end

   assign irq = irq_q;

   a_r11_irq_has_flag: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> stat_q[7]);
   a_r9_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_clear && !commit_live) |=> (stat_q == 8'h00 && !irq));
   a_r6_freeze_no_flags: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && mem[OFS_CTLB][B_FREEZE] && !rd_clear) |=> $stable(stat_q));
   a_r10_valid_fixed: assert property (@(posedge clk) disable iff (!rst_n)
      mem[OFS_VALID] == RST_VALID);
endmodule

// File: tb/rtc_regbank_test.sv
module rtc_regbank_test;
   localparam int UIP = 8;

   logic clk = 1'b0, rst_n = 1'b0;
   logic sel_data = 0, wr_en = 0, rd_en = 0, sec_tick = 0;
   logic [7:0] wdata = 0;
   logic [7:0] tm_sec = 8'h33, tm_min = 8'h45, tm_hour = 8'h12, tm_wday = 8'h03;
   logic [7:0] tm_mday = 8'h28, tm_mon = 8'h02, tm_year = 8'h24;
   logic [7:0] rdata;
   logic irq;
   int checks = 0, errors = 0;
   bit done = 0;

   always #5 clk = ~clk;

   rtc_regbank #(.ADDR_W(7), .UIP_CYCLES(UIP)) uut (
      .clk(clk), .rst_n(rst_n), .sel_data(sel_data), .wr_en(wr_en), .rd_en(rd_en),
      .wdata(wdata), .rdata(rdata), .sec_tick(sec_tick),
      .tm_sec(tm_sec), .tm_min(tm_min), .tm_hour(tm_hour), .tm_wday(tm_wday),
      .tm_mday(tm_mday), .tm_mon(tm_mon), .tm_year(tm_year), .irq(irq));

   // behavioural reference model
   bit [7:0] mm [128];
   int m_idx, m_cnt;
   bit m_busy, m_uip, m_irq;
   bit [7:0] m_c;

   function automatic bit [7:0] m_read(int i);
      if (i == 10) return {m_uip, mm[10][6:0]};
      if (i == 12) return m_c;
      return mm[i];
   endfunction

   always @(posedge clk) begin
      bit osc, frz, fin, live, clr, hit;
      if (!rst_n) begin
         foreach (mm[i]) mm[i] = 0;
         mm[10] = 8'h26; mm[11] = 8'h02; mm[13] = 8'h80;
         m_idx = 0; m_cnt = 0; m_busy = 0; m_uip = 0; m_irq = 0; m_c = 0;
      end else begin
         osc  = (mm[10][6:4] == 3'd2);
         frz  = mm[11][7];
         fin  = m_busy && m_cnt == 1;
         live = fin && !frz;
         clr  = sel_data && rd_en && m_idx == 12;
         hit  = (mm[1][7:6] == 2'b11 || mm[1] == tm_sec) &&
                (mm[3][7:6] == 2'b11 || mm[3] == tm_min) &&
                (mm[5][7:6] == 2'b11 || mm[5] == tm_hour);
         if (clr) begin m_c = 0; m_irq = 0; end
         if (live && mm[11][5] && hit) begin m_c |= 8'hA0; m_irq = 1; end
         if (live && mm[11][4]) begin m_c |= 8'h90; m_irq = 1; end
         if (live) begin
            mm[0] = tm_sec; mm[2] = tm_min; mm[4] = tm_hour; mm[6] = tm_wday;
            mm[7] = tm_mday; mm[8] = tm_mon; mm[9] = tm_year;
         end
         if (sel_data && wr_en && m_idx != 12 && m_idx != 13) mm[m_idx] = wdata;
         if (!sel_data && wr_en && wdata < 128) m_idx = wdata;
         if (m_busy) begin
            if (m_cnt == 1) begin m_busy = 0; m_uip = 0; end
            m_cnt--;
         end else if (sec_tick && osc) begin
            m_busy = 1; m_cnt = UIP; m_uip = !frz;
         end
      end
   end

   task automatic chk(string req, int act, int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   always @(negedge clk) if (rst_n && !done) begin
      chk("R2 model rdata", rdata, m_read(m_idx));
      chk("R11 model irq", irq, m_irq);
   end

   task automatic put_idx(input [7:0] i);
      @(negedge clk); sel_data = 0; wr_en = 1; wdata = i;
      @(negedge clk); wr_en = 0;
   endtask
   task automatic put_data(input [7:0] v);
      @(negedge clk); sel_data = 1; wr_en = 1; wdata = v;
      @(negedge clk); wr_en = 0;
   endtask
   task automatic wr_reg(input [7:0] i, input [7:0] v);
      put_idx(i); put_data(v);
   endtask
   task automatic peek(input [7:0] i, output [7:0] v);
      put_idx(i); v = rdata;
   endtask
   task automatic tick_pulse();
      @(negedge clk); sec_tick = 1;
      @(negedge clk); sec_tick = 0;
   endtask
   task automatic settle();
      repeat (UIP + 3) @(negedge clk);
   endtask

   initial begin
      logic [7:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      peek(10, v); chk("R1 A", v, 8'h26);
      peek(11, v); chk("R1 B", v, 8'h02);
      peek(12, v); chk("R1 C", v, 8'h00);
      peek(13, v); chk("R1 D", v, 8'h80);
      chk("R1 irq", irq, 0);
      // R2 storage and out-of-range index
      wr_reg(40, 8'h5A); peek(40, v); chk("R2 store", v, 8'h5A);
      put_idx(8'h85); chk("R2 index kept", rdata, 8'h5A);
      // R10 read-only bits
      wr_reg(12, 8'hFF); peek(12, v); chk("R10 C write", v, 8'h00);
      wr_reg(13, 8'h00); peek(13, v); chk("R10 D write", v, 8'h80);
      wr_reg(10, 8'hA6); peek(10, v); chk("R10 A bit7", v, 8'h26);
      // R3 stopped oscillator
      wr_reg(10, 8'h06);
      tick_pulse(); chk("R3 no uip", rdata[7], 0);
      settle(); peek(0, v); chk("R3 no copy", v, 8'h00);
      wr_reg(10, 8'h26);
      // R4 window length, R5 copy
      put_idx(10);
      tick_pulse();
      repeat (UIP - 1) @(negedge clk);
      chk("R4 uip last cycle", rdata[7], 1);
      @(negedge clk); chk("R4 uip cleared", rdata[7], 0);
      peek(0, v); chk("R5 sec", v, 8'h33);
      peek(4, v); chk("R5 hour", v, 8'h12);
      peek(9, v); chk("R5 year", v, 8'h24);
      // R4 tick inside an open window is ignored
      put_idx(10); tick_pulse(); tick_pulse(); settle();
      // R6 freeze
      wr_reg(11, 8'hB2); tm_sec = 8'h34;
      put_idx(10); tick_pulse(); chk("R6 no uip", rdata[7], 0);
      settle(); peek(0, v); chk("R6 no copy", v, 8'h33);
      chk("R6 no irq", irq, 0);
      wr_reg(11, 8'h02);
      // R7 alarm with don't-care codes
      wr_reg(1, 8'hC0); wr_reg(3, 8'h45); wr_reg(5, 8'hFF);
      wr_reg(11, 8'h22); tick_pulse(); settle();
      chk("R7 irq", irq, 1);
      peek(12, v); chk("R7 flags", v, 8'hA0);
      // R9 clear on read
      @(negedge clk); sel_data = 1; rd_en = 1;
      @(negedge clk); rd_en = 0;
      chk("R9 irq low", irq, 0); chk("R9 C cleared", rdata, 8'h00);
      // R7 mismatching minutes
      wr_reg(3, 8'h44); tick_pulse(); settle();
      chk("R7 mismatch irq", irq, 0);
      // R8 update-ended
      wr_reg(11, 8'h12); tick_pulse(); settle();
      chk("R8 irq", irq, 1);
      peek(12, v); chk("R8 flags", v, 8'h90);
      @(negedge clk); sel_data = 1; rd_en = 1;
      @(negedge clk); rd_en = 0;
      chk("R9 irq low again", irq, 0);
      repeat (4) @(negedge clk);
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++; errors++;
         $display("FAIL R11 watchdog: actual hung expected done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule